// File: doc/BRIEF.md
# Wide-to-Narrow APB Width Bridge

This block joins a 64-bit APB requester to 32-bit APB completers. Toward the wide side it acts as a completer. Toward the narrow side it acts as a requester. Each wide read or write becomes one or two narrow transfers, and the wide transfer waits in its access phase until those narrow transfers finish.

On a write, the bridge splits the data and the byte strobes into a lower and an upper 32-bit half. The lower half goes to the 8-byte-aligned base address and the upper half goes to base+4. A half whose strobes are all zero is not issued. On a read, both halves are always fetched, lower address first, and the two returned words are joined into one 64-bit result. The wide error response is the OR of the narrow error responses.

The bridge is placed between a wide bus fabric and a group of legacy 32-bit peripherals. It handles one transfer at a time.

Top module: `apb_w2n_bridge`

## Requirements
- R1: After synchronous reset, up_ready, dn_sel and dn_enable are all 0.
- R2: Every narrow transfer has one cycle with dn_sel=1 and dn_enable=0. The next cycle has both at 1, and that state holds with dn_addr, dn_wdata, dn_strb and dn_write unchanged until a cycle in which dn_ready=1.
- R3: A write with both strobe nibbles nonzero issues two narrow writes. The first carries up_wdata[31:0] with strobe up_strb[3:0] to the aligned base address. The second carries up_wdata[63:32] with strobe up_strb[7:4] to base+4.
- R4: A read issues a narrow read at base and then one at base+4. When up_ready rises, up_rdata equals {word from base+4, word from base}.
- R5: up_ready stays 0 until every narrow transfer of the wide transfer has completed. It is then 1 for exactly one cycle, and only while up_sel and up_enable are both 1.
- R6: On a write, a half whose strobe nibble is 0000 is not issued. If only up_strb[7:4] is nonzero, the single transfer goes to base+4.
- R7: A write with up_strb = 8'h00 issues exactly one narrow write, to the base address, with dn_strb = 4'b0000.
- R8: up_slverr, which is valid only while up_ready=1, is the OR of dn_slverr over the narrow transfers. An error on the lower half does not prevent the upper half from being issued.
- R9: Bits [2:0] of up_addr are ignored. The base address is up_addr with those bits cleared.
- R10: During narrow reads dn_strb is 4'b0000, and dn_addr[1:0] is always 0 while dn_sel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_sel | input | 1 | Wide-side select |
| up_enable | input | 1 | Wide-side enable (access phase) |
| up_write | input | 1 | Wide-side direction, 1 = write |
| up_addr | input | 32 | Wide-side byte address |
| up_wdata | input | 64 | Wide-side write data |
| up_strb | input | 8 | Wide-side byte strobes, bit n = byte lane n |
| up_ready | output | 1 | Wide-side transfer completion |
| up_rdata | output | 64 | Wide-side read data |
| up_slverr | output | 1 | Wide-side error response |
| dn_sel | output | 1 | Narrow-side select |
| dn_enable | output | 1 | Narrow-side enable |
| dn_write | output | 1 | Narrow-side direction |
| dn_addr | output | 32 | Narrow-side byte address |
| dn_wdata | output | 32 | Narrow-side write data |
| dn_strb | output | 4 | Narrow-side byte strobes |
| dn_ready | input | 1 | Narrow-side completer ready |
| dn_rdata | input | 32 | Narrow-side read data |
| dn_slverr | input | 1 | Narrow-side error response |

## Verification
The bench drives wide writes with full strobes, with mixed strobes that differ between the halves, with only the lower nibble set, with only the upper nibble set, and with no strobes at all. Comparing the logged narrow transfers tells apart the correct lane and address pairing, the correct skip decisions, and the forced zero-strobe write. Reads of locations with known contents show whether the two words are joined in the right order. An unaligned address shows that the low address bits are discarded. An error injected on only one half at a time separates OR-merging from last-response-wins, and it confirms that the upper half is still issued. Narrow wait states show whether the wide side stalls for the full sequence.

// File: rtl/w2n_pkg.sv
package w2n_pkg;

    localparam int AW        = 32;
    localparam int UP_DW     = 64;
    localparam int DN_DW     = 32;
    localparam int UP_SW     = UP_DW / 8;
    localparam int DN_SW     = DN_DW / 8;
    localparam int NHALF     = UP_DW / DN_DW;
    localparam int ALIGN_LSB = $clog2(UP_SW);
    localparam logic [AW-1:0] HALF_OFS = AW'(DN_SW);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO_SETUP,
        ST_LO_ACCESS,
        ST_HI_SETUP,
        ST_HI_ACCESS,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [AW-1:0]    base;
        logic [UP_DW-1:0] wdata;
        logic [UP_SW-1:0] strb;
        logic             write;
    } wide_req_t;

    function automatic logic [AW-1:0] align_down(input logic [AW-1:0] a);
        return {a[AW-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
    endfunction

    // bit 0: lower half issued, bit 1: upper half issued
    function automatic logic [1:0] halves_needed(input wide_req_t r);
        logic lo, hi;
        if (!r.write) return 2'b11;
        lo = |r.strb[DN_SW-1:0];
        hi = |r.strb[UP_SW-1:DN_SW];
        if (!lo && !hi) return 2'b01;
        return {hi, lo};
    endfunction

endpackage

// File: rtl/w2n_req_capture.sv
module w2n_req_capture
    import w2n_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  wide_req_t req_in,
    output wide_req_t req_q,
    output logic [1:0] need_q
);
    always_ff @(posedge clk) begin
        if (rst)       req_q <= '0;
        else if (load) req_q <= req_in;
    end

    assign need_q = halves_needed(req_q);
endmodule

// File: rtl/w2n_seq_fsm.sv
module w2n_seq_fsm
    import w2n_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] need_now,
    input  logic [1:0] need_q,
    input  logic       dn_ready,
    output seq_state_e state
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start) nxt = need_now[0] ? ST_LO_SETUP : ST_HI_SETUP;
            ST_LO_SETUP:  nxt = ST_LO_ACCESS;
            ST_LO_ACCESS: if (dn_ready) nxt = need_q[1] ? ST_HI_SETUP : ST_DONE;
            ST_HI_SETUP:  nxt = ST_HI_ACCESS;
            ST_HI_ACCESS: if (dn_ready) nxt = ST_DONE;
            ST_DONE:      nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/w2n_resp_collect.sv
module w2n_resp_collect
    import w2n_pkg::*;
#(
    parameter int W  = DN_DW,
    parameter int NH = NHALF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic [NH-1:0]   take,
    input  logic [W-1:0]    word_in,
    input  logic            err_in,
    output logic [NH*W-1:0] merged,
    output logic            err_acc
);
    for (genvar g = 0; g < NH; g++) begin : g_half
        logic [W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)          word_q <= '0;
            else if (take[g]) word_q <= word_in;
        end
        assign merged[g*W +: W] = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)  err_acc <= 1'b0;
        else if (|take)    err_acc <= err_acc | err_in;
    end
endmodule

// File: rtl/apb_w2n_bridge.sv
module apb_w2n_bridge
    import w2n_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             up_sel,
    input  logic             up_enable,
    input  logic             up_write,
    input  logic [AW-1:0]    up_addr,
    input  logic [UP_DW-1:0] up_wdata,
    input  logic [UP_SW-1:0] up_strb,
    output logic             up_ready,
    output logic [UP_DW-1:0] up_rdata,
    output logic             up_slverr,
    output logic             dn_sel,
    output logic             dn_enable,
    output logic             dn_write,
    output logic [AW-1:0]    dn_addr,
    output logic [DN_DW-1:0] dn_wdata,
    output logic [DN_SW-1:0] dn_strb,
    input  logic             dn_ready,
    input  logic [DN_DW-1:0] dn_rdata,
    input  logic             dn_slverr
);
    wide_req_t  req_in, req_q;
    logic [1:0] need_q;
    seq_state_e state;
    logic       start, in_lo, in_hi, in_acc;
    logic [NHALF-1:0] take;
    logic [UP_DW-1:0] merged;
    logic             err_acc;

    logic [DN_DW-1:0] wd_half [NHALF];
    logic [DN_SW-1:0] sb_half [NHALF];

    always_comb begin
        req_in.base  = align_down(up_addr);
        req_in.wdata = up_wdata;
        req_in.strb  = up_strb;
        req_in.write = up_write;
    end

    assign start = (state == ST_IDLE) && up_sel && !up_enable;

    w2n_req_capture cap_i (
        .clk(clk), .rst(rst), .load(start),
        .req_in(req_in), .req_q(req_q), .need_q(need_q)
    );

    w2n_seq_fsm fsm_i (
        .clk(clk), .rst(rst), .start(start),
        .need_now(halves_needed(req_in)), .need_q(need_q),
        .dn_ready(dn_ready), .state(state)
    );

    assign in_lo  = (state == ST_LO_SETUP) || (state == ST_LO_ACCESS);
    assign in_hi  = (state == ST_HI_SETUP) || (state == ST_HI_ACCESS);
    assign in_acc = (state == ST_LO_ACCESS) || (state == ST_HI_ACCESS);

    for (genvar g = 0; g < NHALF; g++) begin : g_split
        assign wd_half[g] = req_q.wdata[g*DN_DW +: DN_DW];
        assign sb_half[g] = req_q.strb[g*DN_SW +: DN_SW];
    end

    assign take[0] = (state == ST_LO_ACCESS) && dn_ready;
    assign take[1] = (state == ST_HI_ACCESS) && dn_ready;

    w2n_resp_collect #(.W(DN_DW), .NH(NHALF)) col_i (
        .clk(clk), .rst(rst), .clear(start), .take(take),
        .word_in(dn_rdata), .err_in(dn_slverr),
        .merged(merged), .err_acc(err_acc)
    );

    assign dn_sel    = in_lo || in_hi;
    assign dn_enable = in_acc;
    assign dn_write  = dn_sel && req_q.write;
    assign dn_addr   = dn_sel ? (req_q.base + (in_hi ? HALF_OFS : '0)) : '0;
    assign dn_wdata  = dn_sel ? wd_half[in_hi] : '0;
    assign dn_strb   = dn_write ? sb_half[in_hi] : '0;

    assign up_ready  = (state == ST_DONE);
    assign up_rdata  = up_ready ? merged : '0;
    assign up_slverr = up_ready && err_acc;
endmodule

// File: rtl/w2n_checker.sv
module w2n_checker
    import w2n_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             up_sel,
    input logic             up_enable,
    input logic             up_ready,
    input logic             up_slverr,
    input logic             dn_sel,
    input logic             dn_enable,
    input logic             dn_write,
    input logic [AW-1:0]    dn_addr,
    input logic [DN_DW-1:0] dn_wdata,
    input logic [DN_SW-1:0] dn_strb,
    input logic             dn_ready
);
    assert_setup_then_access_R2: assert property (@(posedge clk) disable iff (rst)
        (dn_sel && !dn_enable) |=> (dn_sel && dn_enable));

    assert_access_held_R2: assert property (@(posedge clk) disable iff (rst)
        (dn_sel && dn_enable && !dn_ready) |=>
        (dn_sel && dn_enable && $stable(dn_addr) && $stable(dn_wdata)
         && $stable(dn_strb) && $stable(dn_write)));

    assert_ready_in_access_R5: assert property (@(posedge clk) disable iff (rst)
        up_ready |-> (up_sel && up_enable));

    assert_ready_single_R5: assert property (@(posedge clk) disable iff (rst)
        up_ready |=> !up_ready);

    assert_no_ready_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
        dn_sel |-> !up_ready);

    assert_err_with_ready_R8: assert property (@(posedge clk) disable iff (rst)
        up_slverr |-> up_ready);

    assert_read_strb_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (dn_sel && !dn_write) |-> (dn_strb == '0));

    assert_word_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        dn_sel |-> (dn_addr[1:0] == 2'b00));
endmodule

bind apb_w2n_bridge w2n_checker chk_i (
    .clk(clk), .rst(rst), .up_sel(up_sel), .up_enable(up_enable),
    .up_ready(up_ready), .up_slverr(up_slverr), .dn_sel(dn_sel),
    .dn_enable(dn_enable), .dn_write(dn_write), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_strb(dn_strb), .dn_ready(dn_ready)
);

// File: tb/apb_w2n_bridge_tb_top.sv
`timescale 1ns/1ps
module apb_w2n_bridge_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        up_sel = 0, up_enable = 0, up_write = 0;
    logic [31:0] up_addr = 0;
    logic [63:0] up_wdata = 0;
    logic [7:0]  up_strb = 0;
    logic        up_ready, up_slverr;
    logic [63:0] up_rdata;
    logic        dn_sel, dn_enable, dn_write;
    logic [31:0] dn_addr, dn_wdata;
    logic [3:0]  dn_strb;
    logic        dn_ready;
    logic [31:0] dn_rdata;
    logic        dn_slverr;

    apb_w2n_bridge dut_i (.*);

    // narrow completer model
    logic [31:0] mem [64];
    int          wait_n = 0;
    int          cnt;
    logic        rdy;
    logic        err_en = 0;
    logic [31:0] err_addr = 0;
    logic [31:0] lg_addr [64];
    logic        lg_wr   [64];
    logic [3:0]  lg_strb [64];
    logic [31:0] lg_wdata[64];
    int          lg_n;

    assign dn_ready  = rdy;
    assign dn_rdata  = mem[dn_addr[7:2]];
    assign dn_slverr = rdy && err_en && (dn_addr == err_addr);

    initial for (int i = 0; i < 64; i++) mem[i] = '0;

    always @(posedge clk) begin
        if (rst) begin
            rdy <= 0; cnt <= 0; lg_n <= 0;
        end else if (rdy) begin
            rdy <= 0; cnt <= 0;
            if (dn_sel && dn_enable) begin
                lg_addr[lg_n[5:0]]  <= dn_addr;
                lg_wr[lg_n[5:0]]    <= dn_write;
                lg_strb[lg_n[5:0]]  <= dn_strb;
                lg_wdata[lg_n[5:0]] <= dn_wdata;
                lg_n <= lg_n + 1;
                if (dn_write)
                    for (int b = 0; b < 4; b++)
                        if (dn_strb[b]) mem[dn_addr[7:2]][8*b +: 8] <= dn_wdata[8*b +: 8];
            end
        end else if (dn_sel && dn_enable) begin
            if (cnt >= wait_n) rdy <= 1;
            else cnt <= cnt + 1;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [63:0] r_data;
    logic        r_err;
    int          r_cnt;
    int          base_n;

    task automatic xfer(input logic wr, input logic [31:0] a, input logic [63:0] d,
                        input logic [7:0] s);
        base_n = lg_n;
        @(negedge clk);
        up_sel = 1; up_enable = 0; up_write = wr; up_addr = a; up_wdata = d; up_strb = s;
        @(negedge clk);
        up_enable = 1;
        do @(negedge clk); while (!up_ready);
        r_data = up_rdata; r_err = up_slverr; r_cnt = lg_n - base_n;
        @(negedge clk);
        up_sel = 0; up_enable = 0;
    endtask

    task automatic chk_log(input string req, input int i, input logic [31:0] a,
                           input logic w, input logic [3:0] s, input logic [31:0] d);
        chk({req, " addr"}, 64'(lg_addr[base_n + i]), 64'(a));
        chk({req, " dir"},  64'(lg_wr[base_n + i]),   64'(w));
        chk({req, " strb"}, 64'(lg_strb[base_n + i]), 64'(s));
        if (w) chk({req, " wdata"}, 64'(lg_wdata[base_n + i]), 64'(d));
    endtask

    task automatic t_reset;
        chk("R1 up_ready", 64'(up_ready), 0);
        chk("R1 dn_sel", 64'(dn_sel), 0);
        chk("R1 dn_enable", 64'(dn_enable), 0);
    endtask

    task automatic t_full_write;
        xfer(1, 32'h10, 64'h11223344_55667788, 8'hFF);
        chk("R5 count at ready", 64'(r_cnt), 2);
        chk_log("R3 lo", 0, 32'h10, 1, 4'hF, 32'h55667788);
        chk_log("R3 hi", 1, 32'h14, 1, 4'hF, 32'h11223344);
        chk("R8 no err", 64'(r_err), 0);
    endtask

    task automatic t_read_back;
        xfer(0, 32'h10, '0, 8'h00);
        chk("R4 count", 64'(r_cnt), 2);
        chk_log("R4 R10 first read", 0, 32'h10, 0, 4'h0, '0);
        chk_log("R4 R10 second read", 1, 32'h14, 0, 4'h0, '0);
        chk("R4 rdata", r_data, 64'h11223344_55667788);
    endtask

    task automatic t_mixed_strb;
        xfer(1, 32'h20, 64'hA1A2A3A4_B1B2B3B4, 8'h3C);
        chk("R3 mixed count", 64'(r_cnt), 2);
        chk_log("R3 mixed lo", 0, 32'h20, 1, 4'hC, 32'hB1B2B3B4);
        chk_log("R3 mixed hi", 1, 32'h24, 1, 4'h3, 32'hA1A2A3A4);
        xfer(0, 32'h20, '0, 8'h00);
        chk("R4 mixed rdata", r_data, 64'h0000A3A4_B1B20000);
    endtask

    task automatic t_skip;
        xfer(1, 32'h30, 64'hCAFEF00D_DEADBEEF, 8'h0F);
        chk("R6 lo-only count", 64'(r_cnt), 1);
        chk_log("R6 lo-only", 0, 32'h30, 1, 4'hF, 32'hDEADBEEF);
        xfer(1, 32'h38, 64'h01020304_05060708, 8'hF0);
        chk("R6 hi-only count", 64'(r_cnt), 1);
        chk_log("R6 hi-only", 0, 32'h3C, 1, 4'hF, 32'h01020304);
        xfer(0, 32'h38, '0, 8'h00);
        chk("R6 hi-only rdata", r_data, 64'h01020304_00000000);
    endtask

    task automatic t_zero_strb;
        xfer(1, 32'h08, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
        chk("R7 count", 64'(r_cnt), 1);
        chk_log("R7 zero strobe", 0, 32'h08, 1, 4'h0, 32'hFFFFFFFF);
        xfer(0, 32'h08, '0, 8'h00);
        chk("R7 memory untouched", r_data, 64'h0);
    endtask

    task automatic t_unaligned;
        xfer(1, 32'h45, 64'h99887766_55443322, 8'hFF);
        chk("R9 count", 64'(r_cnt), 2);
        chk_log("R9 lo", 0, 32'h40, 1, 4'hF, 32'h55443322);
        chk_log("R9 hi", 1, 32'h44, 1, 4'hF, 32'h99887766);
        xfer(0, 32'h43, '0, 8'h00);
        chk("R9 read rdata", r_data, 64'h99887766_55443322);
    endtask

    task automatic t_errors;
        err_en = 1; err_addr = 32'h10;
        xfer(0, 32'h10, '0, 8'h00);
        chk("R8 lo err", 64'(r_err), 1);
        chk("R8 hi still issued", 64'(r_cnt), 2);
        err_addr = 32'h14;
        xfer(0, 32'h10, '0, 8'h00);
        chk("R8 hi err", 64'(r_err), 1);
        err_en = 0;
        xfer(0, 32'h10, '0, 8'h00);
        chk("R8 err cleared", 64'(r_err), 0);
    endtask

    task automatic t_wait_states;
        wait_n = 3;
        xfer(1, 32'h50, 64'h0BADC0DE_12345678, 8'hFF);
        chk("R5 waited count", 64'(r_cnt), 2);
        chk_log("R2 waited hi", 1, 32'h54, 1, 4'hF, 32'h0BADC0DE);
        xfer(0, 32'h50, '0, 8'h00);
        chk("R2 waited rdata", r_data, 64'h0BADC0DE_12345678);
        wait_n = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset;
        rst = 0;
        @(negedge clk);
        t_full_write;
        t_read_back;
        t_mixed_strb;
        t_skip;
        t_zero_strb;
        t_unaligned;
        t_errors;
        t_wait_states;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule